// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

This block is a register-mapped countdown timer for a per-core interrupt unit. Software writes a start value into the initial-count register. The block then counts that value down at the input clock rate divided by a programmable power of two. When the count expires, it raises an interrupt request tagged with an 8-bit vector taken from the timer's vector entry. The vector entry selects one-shot or periodic operation. In one-shot mode the counter stops at zero. In periodic mode it reloads from the initial count and counts down again.

A request is raised only when two conditions hold: the timer entry is unmasked and a global unit-enable bit is set. That enable bit sits in a separate register, which also holds a spurious vector. Once raised, a request stays asserted until software writes the end-of-interrupt register. A read-only version register reports how many vector entries the unit has. Register access is a simple single-cycle write strobe, and reads are combinational on a 12-bit byte offset.

Top module: `irq_countdown_timer`

## Requirements
- R1: After reset: irq_req is 0 and the current count reads 0. The timer entry reads 0x0001_0000 (masked, one-shot, vector 0). The enable/spurious register reads 0x0000_00FF (unit disabled). The divide register reads 0.
- R2: Offset 0x030 reads {8'h00, NUM_ENTRIES[7:0], 8'h00, VERSION_ID}, with the entry count in bits 23:16.
- R3: A write to offset 0x380 keeps the low CNT_W bits of the data as the initial count and loads the same value into the current count (offset 0x390). The current count then drops by one per divided tick. Writing 0 stops the timer with the count at 0.
- R4: The divide register at 0x3E0 keeps data bits 3, 1 and 0 as a code c = {b3,b1,b0}. Code 3'b111 divides by 1; any other code divides by 2^(c+1). A write to 0x380 or 0x3E0 restarts the prescaler. With an initial count of N and divisor D, expiry is reported exactly N*D cycles after the initial-count write edge.
- R5: Expiry happens on the tick taken while the count is 1. With entry bit 17 clear (one-shot), the count becomes 0 and stays 0 until the next initial-count write.
- R6: With entry bit 17 set (periodic), expiry reloads the count from the initial count, so expiries repeat every N*D cycles.
- R7: Expiry sets irq_req on that clock edge and latches entry bits 7:0 into irq_vector. This happens only when entry bit 16 (mask) is 0 and bit 8 of the enable register at 0x0F0 is 1; otherwise expiry raises nothing.
- R8: irq_req stays high until a write to offset 0x0B0; after that write it is low from the next edge on. An expiry on the same edge as that write wins.
- R9: The current-count register is read-only: a write to 0x390 changes neither it nor the initial count.
- R10: Readback returns only the implemented bits: at 0x320, bits 17, 16 and 7:0; at 0x0F0, bits 8 and 7:0; at 0x3E0, bits 3, 1 and 0. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 12 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| irq_req | output | 1 | Pending interrupt request |
| irq_vector | output | 8 | Vector of the pending request |

## Verification
The bench builds the block with CNT_W = 12 and NUM_ENTRIES = 4. The narrow counter means an oversized initial-count write shows truncation directly. The non-default entry count makes the version field a real check rather than a match on a default. With a narrow counter, small start values reach every divide code, up to divide by 128, in a few hundred cycles each. Periodic reload, masking, the global enable and end-of-interrupt races therefore all fit in a short run, and the behavioural model is compared against the design on every clock.

// File: rtl/irq_countdown_timer.sv
module irq_countdown_timer #(
  parameter int         CNT_W       = 32,
  parameter int         NUM_ENTRIES = 6,
  parameter logic [7:0] VERSION_ID  = 8'h14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq_req,
  output logic [7:0]  irq_vector
);
  localparam logic [11:0] A_VER   = 12'h030;
  localparam logic [11:0] A_EOI   = 12'h0B0;
  localparam logic [11:0] A_EN    = 12'h0F0;
  localparam logic [11:0] A_ENTRY = 12'h320;
  localparam logic [11:0] A_INIT  = 12'h380;
  localparam logic [11:0] A_CUR   = 12'h390;
  localparam logic [11:0] A_DIV   = 12'h3E0;
  localparam int          PRE_W   = 7;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [7:0]       vec_q, svec_q, req_vec_q;
  logic             mask_q, per_q, en_q, req_q;
  logic [2:0]       code_q;
  logic [CNT_W-1:0] init_q, cur_q;
  logic [PRE_W-1:0] pre_q;

  logic wr_eoi, wr_en, wr_entry, wr_init, wr_div;
  assign wr_eoi   = reg_wr && reg_addr == A_EOI;
  assign wr_en    = reg_wr && reg_addr == A_EN;
  assign wr_entry = reg_wr && reg_addr == A_ENTRY;
  assign wr_init  = reg_wr && reg_addr == A_INIT;
  assign wr_div   = reg_wr && reg_addr == A_DIV;

  logic [2:0]       shift;
  logic [PRE_W-1:0] pre_top;
  logic             running, tick, expire, fire;
  assign shift   = (code_q == 3'b111) ? 3'd0 : code_q + 3'd1;
  assign pre_top = ~({PRE_W{1'b1}} << shift);
  assign running = cur_q != '0;
  assign tick    = running && pre_q == pre_top && !wr_div;
  assign expire  = tick && cur_q == ONE;
  assign fire    = expire && !mask_q && en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q  <= 8'h00;
      mask_q <= 1'b1;
      per_q  <= 1'b0;
      svec_q <= 8'hFF;
      en_q   <= 1'b0;
      code_q <= 3'b000;
    end else begin
      if (wr_entry) begin
        vec_q  <= reg_wdata[7:0];
        mask_q <= reg_wdata[16];
        per_q  <= reg_wdata[17];
      end
      if (wr_en) begin
        svec_q <= reg_wdata[7:0];
        en_q   <= reg_wdata[8];
      end
      if (wr_div) code_q <= {reg_wdata[3], reg_wdata[1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_q <= '0;
      cur_q  <= '0;
      pre_q  <= '0;
    end else begin
      if (wr_init) init_q <= reg_wdata[CNT_W-1:0];
      if (wr_init)     cur_q <= reg_wdata[CNT_W-1:0];
      else if (expire) cur_q <= per_q ? init_q : '0;
      else if (tick)   cur_q <= cur_q - ONE;
      if (wr_init || wr_div) pre_q <= '0;
      else if (running)      pre_q <= (pre_q == pre_top) ? '0 : pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q     <= 1'b0;
      req_vec_q <= 8'h00;
    end else if (fire) begin
      req_q     <= 1'b1;
      req_vec_q <= vec_q;
    end else if (wr_eoi) begin
      req_q <= 1'b0;
    end
  end

  assign irq_req    = req_q;
  assign irq_vector = req_vec_q;

  always_comb begin
    case (reg_addr)
      A_VER:   reg_rdata = {8'h00, NUM_ENTRIES[7:0], 8'h00, VERSION_ID};
      A_EN:    reg_rdata = {23'b0, en_q, svec_q};
      A_ENTRY: reg_rdata = {14'b0, per_q, mask_q, 8'h00, vec_q};
      A_INIT:  reg_rdata = 32'(init_q);
      A_CUR:   reg_rdata = 32'(cur_q);
      A_DIV:   reg_rdata = {28'b0, code_q[2], 1'b0, code_q[1:0]};
      default: reg_rdata = 32'h0;
    endcase
  end

  a_r8_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && !wr_eoi |=> irq_req);
  a_r8_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_eoi && !expire |=> !irq_req);
  a_r7_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req && (mask_q || !en_q) |=> !irq_req);
  a_r7_vector: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> irq_vector == $past(vec_q));
  a_r5_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
    cur_q == '0 && !wr_init |=> cur_q == '0);
  a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    tick && cur_q > ONE && !wr_init |=> cur_q == $past(cur_q) - ONE);
  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    expire && per_q && !wr_init |=> cur_q == $past(init_q));
  a_r4_pre_range: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= pre_top);
endmodule

// File: tb/irq_countdown_timer_bench.sv
module irq_countdown_timer_bench;
  localparam int CW = 12;
  logic clk = 0, rst_n = 0, reg_wr = 0;
  logic [11:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq_req;
  logic [7:0] irq_vector;
  int checks = 0, errors = 0;
  bit live = 0, done = 0;

  always #2.5 clk = ~clk;

  irq_countdown_timer #(.CNT_W(CW), .NUM_ENTRIES(4), .VERSION_ID(8'h14)) u_irq_countdown_timer (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_vector(irq_vector));

  // behavioural reference model
  int m_cur, m_init, m_pre, m_code, m_vec, m_svec, m_rvec;
  bit m_mask, m_per, m_en, m_req;
  int t_div; bit t_tick, t_exp;

  function automatic int divisor(int c);
    return (c == 7) ? 1 : (1 << (c + 1));
  endfunction

  function automatic logic [31:0] model_read(logic [11:0] a);
    case (a)
      12'h030: return 32'h0004_0014;
      12'h0F0: return (m_en ? 32'h100 : 0) | m_svec;
      12'h320: return (m_per ? 32'h20000 : 0) | (m_mask ? 32'h10000 : 0) | m_vec;
      12'h380: return m_init;
      12'h390: return m_cur;
      12'h3E0: return ((m_code & 4) << 1) | (m_code & 3);
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cur = 0; m_init = 0; m_pre = 0; m_code = 0; m_vec = 0; m_svec = 8'hFF;
      m_rvec = 0; m_mask = 1; m_per = 0; m_en = 0; m_req = 0;
    end else begin
      t_div  = divisor(m_code);
      t_tick = (m_cur != 0) && (m_pre == t_div - 1) && !(reg_wr && reg_addr == 12'h3E0);
      t_exp  = t_tick && m_cur == 1;
      if (t_exp && !m_mask && m_en) begin m_req = 1; m_rvec = m_vec; end
      else if (reg_wr && reg_addr == 12'h0B0) m_req = 0;
      if (reg_wr && reg_addr == 12'h380) begin
        m_init = reg_wdata & 32'hFFF; m_cur = m_init; m_pre = 0;
      end else begin
        if (m_cur != 0) m_pre = (m_pre == t_div - 1 || t_tick) ? 0 : m_pre + 1;
        if (t_exp) m_cur = m_per ? m_init : 0;
        else if (t_tick) m_cur = m_cur - 1;
        if (reg_wr && reg_addr == 12'h3E0) m_pre = 0;
      end
      if (reg_wr && reg_addr == 12'h320) begin
        m_vec = reg_wdata[7:0]; m_mask = reg_wdata[16]; m_per = reg_wdata[17];
      end
      if (reg_wr && reg_addr == 12'h0F0) begin m_svec = reg_wdata[7:0]; m_en = reg_wdata[8]; end
      if (reg_wr && reg_addr == 12'h3E0) m_code = {reg_wdata[3], reg_wdata[1:0]};
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (live) begin
    check("R8 irq_req vs model", {31'b0, irq_req}, {31'b0, m_req});
    if (m_req) check("R7 irq_vector vs model", {24'b0, irq_vector}, m_rvec);
    check(reg_addr == 12'h390 ? "R3 current count vs model" :
          reg_addr == 12'h030 ? "R2 version vs model" : "R10 readback vs model",
          reg_rdata, model_read(reg_addr));
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); #0.5; reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #0.5; reg_wr = 0;
  endtask

  task automatic rd(logic [11:0] a, string tag, logic [31:0] exp);
    @(negedge clk); #0.5; reg_addr = a; #1; check(tag, reg_rdata, exp);
  endtask

  task automatic wait_req(output int n);
    n = 0;
    while (!irq_req && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic idle(int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    int n;
    int codes[8] = '{32'h0, 32'h1, 32'h2, 32'h3, 32'h8, 32'h9, 32'hA, 32'hB};
    repeat (3) @(negedge clk);
    rst_n = 1; live = 1;
    rd(12'h320, "R1 entry reset", 32'h0001_0000);
    rd(12'h0F0, "R1 enable reset", 32'h0000_00FF);
    rd(12'h390, "R1 count reset", 0);
    rd(12'h3E0, "R1 divide reset", 0);
    check("R1 irq_req reset", {31'b0, irq_req}, 0);
    rd(12'h030, "R2 version", 32'h0004_0014);
    wr(12'h320, 32'hFFFF_FFFF); rd(12'h320, "R10 entry bits", 32'h0003_00FF);
    wr(12'h3E0, 32'hFFFF_FFFF); rd(12'h3E0, "R10 divide bits", 32'h0000_000B);
    wr(12'h0F0, 32'hFFFF_FFA5); rd(12'h0F0, "R10 enable bits", 32'h0000_01A5);
    wr(12'h100, 32'h1234_5678); rd(12'h100, "R10 unmapped", 0);
    wr(12'h390, 32'h55); rd(12'h390, "R9 write to count ignored", 0);
    rd(12'h380, "R9 initial untouched", 0);
    wr(12'h380, 32'h1005); rd(12'h380, "R3 initial truncated", 32'h005);
    wr(12'h380, 0); rd(12'h390, "R3 zero stops", 0);
    // one-shot, divide by 1
    wr(12'h320, 32'h40); wr(12'h380, 5); wait_req(n);
    check("R4 div1 expiry cycles", n, 5);
    check("R7 vector", {24'b0, irq_vector}, 32'h40);
    rd(12'h390, "R5 one-shot holds zero", 0); idle(20);
    rd(12'h390, "R5 one-shot still zero", 0);
    check("R8 request held", {31'b0, irq_req}, 1);
    wr(12'h0B0, 0); check("R8 cleared by EOI", {31'b0, irq_req}, 0);
    // each divide code, one-shot, count 3
    foreach (codes[i]) begin
      wr(12'h3E0, codes[i]); wr(12'h380, 3); wait_req(n);
      check("R4 divided expiry cycles", n, 3 * divisor({codes[i][3], codes[i][1:0]}));
      wr(12'h0B0, 0);
    end
    // periodic, divide by 1
    wr(12'h3E0, 32'hB); wr(12'h320, 32'h0002_0033); wr(12'h380, 4); wait_req(n);
    check("R6 first period", n, 4); wr(12'h0B0, 0); wait_req(n);
    check("R6 reload period", n, 2);
    check("R6 vector", {24'b0, irq_vector}, 32'h33);
    wr(12'h0B0, 0); wait_req(n); check("R6 steady period", n, 2);
    wr(12'h380, 0); wr(12'h0B0, 0); idle(20);
    check("R3 stopped no request", {31'b0, irq_req}, 0);
    // periodic with divide by 2, then EOI racing expiry
    wr(12'h3E0, 32'h0); wr(12'h380, 2); idle(30); wr(12'h0B0, 0); idle(9);
    wr(12'h380, 0); wr(12'h0B0, 0);
    // masked, then globally disabled
    wr(12'h3E0, 32'hB); wr(12'h320, 32'h0001_0021); wr(12'h380, 3); idle(12);
    check("R7 masked no request", {31'b0, irq_req}, 0);
    wr(12'h320, 32'h21); wr(12'h0F0, 32'hFF); wr(12'h380, 3); idle(12);
    check("R7 disabled no request", {31'b0, irq_req}, 0);
    wr(12'h0F0, 32'h1FF); wr(12'h380, 3); idle(6);
    check("R7 enabled request", {31'b0, irq_req}, 1);
    idle(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule